// File: doc/BRIEF.md
# Cipher Key Register Bank

This block stores the key for a block cipher as a bank of 64-bit words. The key can be 16, 24 or 32 bytes long. The host loads the key one word at a time over a small register write port. A size input sets how many bytes of the key are active. Writes to word slots past that length are dropped.

The whole bank is presented to the cipher core as one wide vector. Slots beyond the active length read as zero on that vector. The host can read any stored word back, so that a decrypt context can be saved and later written back. A restore mode bit, set together with that write-back, tells the core to use the stored key as it is and skip key expansion. If the host tries to write a key word while the core reports that a message is being processed, the write is refused and a sticky context error is raised.

Top module: `cipher_key_bank`

## Requirements
- R1: After a synchronous reset, every stored word is zero, the active size is 16 bytes, the restore flag is 0 and the context error is 0.
- R2: A key write with index i stores its 64-bit data in word i, where word 0 holds the first 8 key bytes. On `key_vec`, word i occupies bits [64*i+63 : 64*i].
- R3: A key write whose index is at or beyond the active word count is discarded, and no stored word changes. The active word count is 2 for 16 bytes, 3 for 24 bytes and 4 for 32 bytes.
- R4: A size write with byte count 16, 24 or 32 changes the active size on the next cycle. Any other byte count is rejected and the previous size is kept. `key_bytes` reports the active size in bytes.
- R5: A key write while `busy` is 1 sets `ctx_err` on the next cycle and leaves every stored word unchanged.
- R6: `ctx_err` stays 1 until reset or re-initialization, whatever writes follow.
- R7: `rd_data` combinationally returns the raw stored word selected by `rd_idx`, including words beyond the active length, and also while `busy` is 1.
- R8: A mode write loads `mode_restore` into the restore flag, which then holds its value until the next mode write, reset or re-initialization.
- R9: On `key_vec`, words at or beyond the active word count read as zero, while their stored contents are kept.
- R10: A pulse on `init` clears the bank to the same state as reset. If a key write arrives in the same cycle, `init` takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init | input | 1 | Re-initialization pulse, clears like reset |
| wr_en | input | 1 | Key word write strobe |
| wr_idx | input | 2 | Key word index for the write |
| wr_data | input | 64 | Key word write data |
| rd_idx | input | 2 | Key word index for readback |
| rd_data | output | 64 | Stored key word at rd_idx |
| size_we | input | 1 | Key size write strobe |
| size_bytes | input | 6 | Requested key length in bytes |
| mode_we | input | 1 | Mode write strobe |
| mode_restore | input | 1 | Restore-decrypt-key bit for the mode write |
| busy | input | 1 | Cipher core is processing a message |
| key_vec | output | 256 | Key words concatenated, inactive words zero |
| key_bytes | output | 6 | Active key length in bytes |
| restore_o | output | 1 | Core must use the key without expansion |
| ctx_err | output | 1 | Sticky context error |

## Verification
The bench builds the bank with its defaults: four 64-bit words and a 6-bit size field. With these values every legal size (2, 3 and 4 active words) and every index that is out of range for the smaller sizes can be reached with a 2-bit index. The vector table grows the key size step by step. It places writes just past the current limit, both before and after each size change, and mixes in illegal byte counts. Directed tests then shrink the size again to show that `key_vec` masks the upper words while readback still shows them. They also cover busy-time writes, and the case where `init` and a write land in the same cycle.

// File: rtl/keybank_pkg.sv
package keybank_pkg;

    localparam int WORD_W = 64;
    localparam int NWORDS = 4;
    localparam int IDX_W  = $clog2(NWORDS);
    localparam int SIZE_W = 6;

    typedef enum logic [1:0] {
        KLEN_16B = 2'd0,
        KLEN_24B = 2'd1,
        KLEN_32B = 2'd2
    } klen_e;

    typedef struct packed {
        logic              en;
        logic [IDX_W-1:0]  idx;
        logic [WORD_W-1:0] data;
    } kwr_t;

    function automatic logic size_legal(input logic [SIZE_W-1:0] nbytes);
        return (nbytes == SIZE_W'(16)) || (nbytes == SIZE_W'(24)) ||
               (nbytes == SIZE_W'(32));
    endfunction

    function automatic klen_e bytes_to_len(input logic [SIZE_W-1:0] nbytes);
        case (nbytes)
            SIZE_W'(24): return KLEN_24B;
            SIZE_W'(32): return KLEN_32B;
            default:     return KLEN_16B;
        endcase
    endfunction

    function automatic logic [SIZE_W-1:0] len_to_bytes(input klen_e len);
        case (len)
            KLEN_24B: return SIZE_W'(24);
            KLEN_32B: return SIZE_W'(32);
            default:  return SIZE_W'(16);
        endcase
    endfunction

    function automatic logic [IDX_W:0] len_to_words(input klen_e len);
        case (len)
            KLEN_24B: return (IDX_W+1)'(3);
            KLEN_32B: return (IDX_W+1)'(4);
            default:  return (IDX_W+1)'(2);
        endcase
    endfunction

endpackage

// File: rtl/kb_size_reg.sv
module kb_size_reg
    import keybank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              init,
    input  logic              size_we,
    input  logic [SIZE_W-1:0] size_bytes,
    output klen_e             len_o,
    output logic [IDX_W:0]    active_words,
    output logic [SIZE_W-1:0] bytes_o
);

    klen_e len_q;

    always_ff @(posedge clk) begin
        if (rst || init) begin
            len_q <= KLEN_16B;
        end else if (size_we && size_legal(size_bytes)) begin
            len_q <= bytes_to_len(size_bytes);
        end
    end

    assign len_o        = len_q;
    assign active_words = len_to_words(len_q);
    assign bytes_o      = len_to_bytes(len_q);

endmodule

// File: rtl/kb_wr_ctrl.sv
module kb_wr_ctrl
    import keybank_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           init,
    input  kwr_t           req,
    input  logic           busy,
    input  logic [IDX_W:0] active_words,
    output kwr_t           commit,
    output logic           err_o
);

    logic in_range;
    logic err_q;

    assign in_range = ({1'b0, req.idx} < active_words);

    always_comb begin
        commit      = req;
        commit.en   = req.en && !busy && in_range && !init;
    end

    always_ff @(posedge clk) begin
        if (rst || init) begin
            err_q <= 1'b0;
        end else if (req.en && busy) begin
            err_q <= 1'b1;
        end
    end

    assign err_o = err_q;

endmodule

// File: rtl/kb_store.sv
module kb_store
    import keybank_pkg::*;
#(
    parameter int N_W   = NWORDS,
    parameter int W     = WORD_W,
    localparam int IW   = $clog2(N_W)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           init,
    input  logic           wr_en,
    input  logic [IW-1:0]  wr_idx,
    input  logic [W-1:0]   wr_data,
    input  logic [IW:0]    active_words,
    input  logic [IW-1:0]  rd_idx,
    output logic [W-1:0]   rd_data,
    output logic [N_W*W-1:0] key_vec
);

    logic [W-1:0] mem [N_W];

    for (genvar g = 0; g < N_W; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst || init) begin
                mem[g] <= '0;
            end else if (wr_en && (wr_idx == IW'(g))) begin
                mem[g] <= wr_data;
            end
        end
        assign key_vec[g*W +: W] = ((IW+1)'(g) < active_words) ? mem[g] : '0;
    end

    assign rd_data = mem[rd_idx];

endmodule

// File: rtl/cipher_key_bank.sv
module cipher_key_bank
    import keybank_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     init,
    input  logic                     wr_en,
    input  logic [IDX_W-1:0]         wr_idx,
    input  logic [WORD_W-1:0]        wr_data,
    input  logic [IDX_W-1:0]         rd_idx,
    output logic [WORD_W-1:0]        rd_data,
    input  logic                     size_we,
    input  logic [SIZE_W-1:0]        size_bytes,
    input  logic                     mode_we,
    input  logic                     mode_restore,
    input  logic                     busy,
    output logic [NWORDS*WORD_W-1:0] key_vec,
    output logic [SIZE_W-1:0]        key_bytes,
    output logic                     restore_o,
    output logic                     ctx_err
);

    klen_e          len;
    logic [IDX_W:0] active_words;
    kwr_t           req;
    kwr_t           commit;
    logic           restore_q;

    assign req = '{en: wr_en, idx: wr_idx, data: wr_data};

    kb_size_reg u_size (
        .clk          (clk),
        .rst          (rst),
        .init         (init),
        .size_we      (size_we),
        .size_bytes   (size_bytes),
        .len_o        (len),
        .active_words (active_words),
        .bytes_o      (key_bytes)
    );

    kb_wr_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .init         (init),
        .req          (req),
        .busy         (busy),
        .active_words (active_words),
        .commit       (commit),
        .err_o        (ctx_err)
    );

    kb_store #(.N_W(NWORDS), .W(WORD_W)) u_store (
        .clk          (clk),
        .rst          (rst),
        .init         (init),
        .wr_en        (commit.en),
        .wr_idx       (commit.idx),
        .wr_data      (commit.data),
        .active_words (active_words),
        .rd_idx       (rd_idx),
        .rd_data      (rd_data),
        .key_vec      (key_vec)
    );

    always_ff @(posedge clk) begin
        if (rst || init) begin
            restore_q <= 1'b0;
        end else if (mode_we) begin
            restore_q <= mode_restore;
        end
    end

    assign restore_o = restore_q;

    logic unused_len;
    assign unused_len = ^len;

endmodule

// File: rtl/kb_checker.sv
module kb_checker
    import keybank_pkg::*;
(
    input logic                     clk,
    input logic                     rst,
    input logic                     init,
    input logic                     wr_en,
    input logic [IDX_W-1:0]         wr_idx,
    input logic                     size_we,
    input logic                     mode_we,
    input logic                     busy,
    input logic [NWORDS*WORD_W-1:0] key_vec,
    input logic [SIZE_W-1:0]        key_bytes,
    input logic                     restore_o,
    input logic                     ctx_err
);

    logic [IDX_W:0] words_now;
    assign words_now = (IDX_W+1)'(key_bytes >> 3);

    p_init_clear_r10: assert property (@(posedge clk) disable iff (rst)
        init |=> (key_vec == '0 && !ctx_err && !restore_o && key_bytes == SIZE_W'(16)));

    p_busy_write_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && busy && !init && !size_we) |=> (ctx_err && $stable(key_vec)));

    p_err_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (ctx_err && !init) |=> ctx_err);

    p_out_of_range_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !busy && !init && !size_we && ({1'b0, wr_idx} >= words_now))
        |=> $stable(key_vec));

    p_size_legal_r4: assert property (@(posedge clk) disable iff (rst)
        (key_bytes == SIZE_W'(16)) || (key_bytes == SIZE_W'(24)) ||
        (key_bytes == SIZE_W'(32)));

    p_restore_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!mode_we && !init) |=> $stable(restore_o));

endmodule

bind cipher_key_bank kb_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .init      (init),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .size_we   (size_we),
    .mode_we   (mode_we),
    .busy      (busy),
    .key_vec   (key_vec),
    .key_bytes (key_bytes),
    .restore_o (restore_o),
    .ctx_err   (ctx_err)
);

// File: tb/cipher_key_bank_bench.sv
`timescale 1ns/1ps
module cipher_key_bank_bench;

    logic         clk = 1'b0;
    logic         rst, init, wr_en, size_we, mode_we, mode_restore, busy;
    logic [1:0]   wr_idx, rd_idx;
    logic [63:0]  wr_data, rd_data;
    logic [5:0]   size_bytes, key_bytes;
    logic [255:0] key_vec;
    logic         restore_o, ctx_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    cipher_key_bank u_cipher_key_bank (
        .clk(clk), .rst(rst), .init(init), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data),
        .size_we(size_we), .size_bytes(size_bytes), .mode_we(mode_we),
        .mode_restore(mode_restore), .busy(busy), .key_vec(key_vec),
        .key_bytes(key_bytes), .restore_o(restore_o), .ctx_err(ctx_err)
    );

    localparam logic [63:0] A0 = 64'h0011223344556677;
    localparam logic [63:0] A1 = 64'h8899AABBCCDDEEFF;
    localparam logic [63:0] C2 = 64'hC2C2C2C2C2C2C2C2;
    localparam logic [63:0] A2 = 64'h0F1E2D3C4B5A6978;
    localparam logic [63:0] B3 = 64'hB3B3B3B3B3B3B3B3;
    localparam logic [63:0] A3 = 64'hFEDCBA9876543210;
    localparam logic [63:0] DB = 64'hDEADBEEFDEADBEEF;
    localparam logic [63:0] X1 = 64'h1357924680ACE0BD;

    typedef struct packed {
        logic [1:0]  op;      // 0 key write, 1 size write
        logic [1:0]  idx;
        logic [63:0] data;
        logic        bsy;
        logic [1:0]  rd;
        logic [63:0] exp_rd;
        logic        exp_err;
        logic [5:0]  exp_bytes;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 2'd0, A0,    1'b0, 2'd0, A0,    1'b0, 6'd16, 4'd2},  // R2
        '{2'd0, 2'd1, A1,    1'b0, 2'd1, A1,    1'b0, 6'd16, 4'd2},  // R2
        '{2'd0, 2'd2, C2,    1'b0, 2'd2, 64'd0, 1'b0, 6'd16, 4'd3},  // R3
        '{2'd1, 2'd0, 64'd24,1'b0, 2'd2, 64'd0, 1'b0, 6'd24, 4'd4},  // R4
        '{2'd0, 2'd2, A2,    1'b0, 2'd2, A2,    1'b0, 6'd24, 4'd2},  // R2
        '{2'd0, 2'd3, B3,    1'b0, 2'd3, 64'd0, 1'b0, 6'd24, 4'd3},  // R3
        '{2'd1, 2'd0, 64'd20,1'b0, 2'd3, 64'd0, 1'b0, 6'd24, 4'd4},  // R4
        '{2'd1, 2'd0, 64'd32,1'b0, 2'd3, 64'd0, 1'b0, 6'd32, 4'd4},  // R4
        '{2'd0, 2'd3, A3,    1'b0, 2'd3, A3,    1'b0, 6'd32, 4'd2},  // R2
        '{2'd1, 2'd0, 64'd0, 1'b0, 2'd3, A3,    1'b0, 6'd32, 4'd4},  // R4
        '{2'd0, 2'd0, DB,    1'b1, 2'd0, A0,    1'b1, 6'd32, 4'd5},  // R5
        '{2'd0, 2'd1, X1,    1'b0, 2'd1, X1,    1'b1, 6'd32, 4'd6}   // R6
    };

    task automatic check(input string req, input logic [255:0] act,
                         input logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        wr_en = 0; size_we = 0; mode_we = 0; init = 0; rst = 0;
    endtask

    task automatic step();
        @(negedge clk);
        idle();
        #1;
    endtask

    initial begin
        #(20 * 5000);
        fails++;
        checks++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        idle(); busy = 0; mode_restore = 0; wr_idx = 0; wr_data = 0;
        rd_idx = 0; size_bytes = 0;
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        // R1 reset state
        check("R1", {255'd0, ctx_err | restore_o}, 256'd0);
        check("R1", key_vec, 256'd0);
        check("R1", {250'd0, key_bytes}, 256'd16);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            busy = VEC[i].bsy;
            if (VEC[i].op == 2'd0) begin
                wr_en = 1; wr_idx = VEC[i].idx; wr_data = VEC[i].data;
            end else begin
                size_we = 1; size_bytes = VEC[i].data[5:0];
            end
            step();
            busy = 0;
            rd_idx = VEC[i].rd;
            #1;
            check($sformatf("R%0d", VEC[i].req), {192'd0, rd_data}, {192'd0, VEC[i].exp_rd});
            check($sformatf("R%0d", VEC[i].req), {255'd0, ctx_err}, {255'd0, VEC[i].exp_err});
            check($sformatf("R%0d", VEC[i].req), {250'd0, key_bytes}, {250'd0, VEC[i].exp_bytes});
        end

        // R2 word placement on key_vec
        check("R2", key_vec, {A3, A2, X1, A0});

        // R9 shrink to 16 bytes: upper words masked, storage kept (R7)
        @(negedge clk); size_we = 1; size_bytes = 6'd16;
        step();
        check("R9", key_vec, {64'd0, 64'd0, X1, A0});
        rd_idx = 2'd3; #1;
        check("R7", {192'd0, rd_data}, {192'd0, A3});
        busy = 1; rd_idx = 2'd2; #1;
        check("R7", {192'd0, rd_data}, {192'd0, A2});
        busy = 0;

        // R8 restore flag set and held
        @(negedge clk); mode_we = 1; mode_restore = 1;
        step();
        check("R8", {255'd0, restore_o}, 256'd1);
        @(negedge clk); wr_en = 1; wr_idx = 0; wr_data = A1;
        step();
        check("R8", {255'd0, restore_o}, 256'd1);
        check("R2", {192'd0, key_vec[63:0]}, {192'd0, A1});

        // R10 init with simultaneous write clears everything
        @(negedge clk); init = 1; wr_en = 1; wr_idx = 1; wr_data = DB;
        step();
        check("R10", key_vec, 256'd0);
        rd_idx = 2'd3; #1;
        check("R10", {192'd0, rd_data}, 256'd0);
        check("R10", {254'd0, restore_o, ctx_err}, 256'd0);
        check("R10", {250'd0, key_bytes}, 256'd16);

        // R1 mid-run reset
        @(negedge clk); mode_we = 1; mode_restore = 1;
        step();
        @(negedge clk); busy = 1; wr_en = 1; wr_idx = 0; wr_data = DB;
        step();
        busy = 0;
        check("R5", {255'd0, ctx_err}, 256'd1);
        @(negedge clk); rst = 1;
        step();
        check("R1", {254'd0, restore_o, ctx_err}, 256'd0);
        check("R1", key_vec, 256'd0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule